// File: doc/BRIEF.md
# Three-Channel Linear Slider Position Calculator

This block turns three per-channel signal deltas from a capacitive linear slider into a touch flag and a 7-bit position. One delta comes from the channel wired to both slider ends through resistors (the end channel). The other two come from the interior sense nodes at roughly one third (node 1) and two thirds (node 2) of the slider length. The deltas are the raw counts minus a baseline, and they are produced upstream.

A touch counts only when the channels disagree. The spread between the largest and the smallest delta must exceed a threshold, so a change shared equally by all three channels is rejected. The position is interpolated from the ratio of the two channels that bracket the finger. Node 1 reads 45 and node 2 reads 83. Fixed end-stop zones saturate to 0 at the left end and to 127 at the right end. The result is registered one cycle after the input strobe, and a status byte packs the touch flag above the position.

Top module: `slider_pos_top`

## Requirements
- R1: One cycle after `in_valid_i`, `touch_o` is 1 exactly when (largest delta − smallest delta) > `THRESH` (default 40); a spread equal to `THRESH` gives 0.
- R2: Three equal deltas, whatever their size, give `touch_o` = 0.
- R3: Left segment: f = floor(node1·256/(end+node1)); if f < `END_ZONE` (default 77) the position is 0, else 1 + floor((f−END_ZONE)·44/(256−END_ZONE)).
- R4: Middle segment: f = floor(node2·256/(node1+node2)); the position is 45 + floor(f·38/256), so node 1 alone gives 45 and node 2 alone gives 83.
- R5: Right segment: f = floor(end·256/(node2+end)); if f ≥ 256−END_ZONE the position is 127, else 83 + floor(f·43/(256−END_ZONE)).
- R6: The segment is middle when end ≤ node1 and end ≤ node2. Otherwise it is left when node1 ≥ node2 and right when node1 < node2.
- R7: `out_valid_o` pulses exactly one cycle after each cycle with `in_valid_i` high, and the outputs of that sample appear in the same cycle.
- R8: A sample without touch leaves `pos_o` at its last touched value. `status_o` is {touch_o, pos_o}, so bit 7 is the touch flag and bits 6:0 are the position.
- R9: After reset `touch_o`, `pos_o`, `status_o` and `out_valid_o` are all 0.
- R10: Cycles with `in_valid_i` low change neither `touch_o` nor `pos_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | The three deltas are valid this cycle |
| end_delta_i | input | DW | Delta of the channel tied to both slider ends |
| node1_delta_i | input | DW | Delta of the left interior node |
| node2_delta_i | input | DW | Delta of the right interior node |
| out_valid_o | output | 1 | A result was registered this cycle |
| touch_o | output | 1 | Imbalance touch detected |
| pos_o | output | 7 | Position, 0 at the left end to 127 at the right end |
| status_o | output | 8 | {touch_o, pos_o} |

## Verification
On every cycle the checker verifies several things. It checks the one-cycle valid latency. It recomputes detection from pairwise absolute differences and compares the result. It confirms that common-mode samples give no detection and that idle cycles and untouched samples freeze the outputs. It also checks the node-1 anchor value. The exact interpolation values, the boundaries of the end-stop zones and the tie rules of segment selection are arithmetic over whole sample sequences, so only the bench scenarios show them. The bench compares every result against a model worked out from the formulas in the requirements.

// File: rtl/slider_pkg.sv
package slider_pkg;

   typedef enum logic [1:0] {
      SEG_LEFT  = 2'd0,
      SEG_MID   = 2'd1,
      SEG_RIGHT = 2'd2
   } seg_e;

   localparam int POS_W     = 7;
   localparam int POS_TOP   = 127;
   localparam int POS_NODE1 = 45;
   localparam int POS_NODE2 = 83;

endpackage

// File: rtl/slider_spread.sv
module slider_spread #(
   parameter int DW     = 12,
   parameter int THRESH = 40
) (
   input  logic [DW-1:0]      ch_end,
   input  logic [DW-1:0]      ch_n1,
   input  logic [DW-1:0]      ch_n2,
   output logic               touch,
   output slider_pkg::seg_e   seg,
   output logic [DW-1:0]      num,
   output logic [DW:0]        den
);
   import slider_pkg::*;

   localparam int NCH = 3;
   localparam logic [DW-1:0] THR_V = DW'(THRESH);

   logic [DW-1:0] ch  [NCH];
   logic [DW-1:0] mx  [NCH];
   logic [DW-1:0] mn  [NCH];
   logic [DW-1:0] spread;

   assign ch[0] = ch_end;
   assign ch[1] = ch_n1;
   assign ch[2] = ch_n2;

   assign mx[0] = ch[0];
   assign mn[0] = ch[0];

   // running max/min chain across the channels
   generate
      for (genvar i = 1; i < NCH; i++) begin : g_rank
         assign mx[i] = (ch[i] > mx[i-1]) ? ch[i] : mx[i-1];
         assign mn[i] = (ch[i] < mn[i-1]) ? ch[i] : mn[i-1];
      end
   endgenerate

   assign spread = mx[NCH-1] - mn[NCH-1];
   assign touch  = (spread > THR_V);

   always_comb begin
      if ((ch_end <= ch_n1) && (ch_end <= ch_n2)) begin
         seg = SEG_MID;
         num = ch_n2;
         den = {1'b0, ch_n1} + {1'b0, ch_n2};
      end else if (ch_n1 >= ch_n2) begin
         seg = SEG_LEFT;
         num = ch_n1;
         den = {1'b0, ch_end} + {1'b0, ch_n1};
      end else begin
         seg = SEG_RIGHT;
         num = ch_end;
         den = {1'b0, ch_n2} + {1'b0, ch_end};
      end
   end

endmodule

// File: rtl/slider_interp.sv
module slider_interp #(
   parameter int DW       = 12,
   parameter int FB       = 8,
   parameter int END_ZONE = 77
) (
   input  slider_pkg::seg_e   seg,
   input  logic [DW-1:0]      num,
   input  logic [DW:0]        den,
   output logic [6:0]         pos
);
   import slider_pkg::*;

   localparam int ONE  = 1 << FB;
   localparam int SPAN = ONE - END_ZONE;
   localparam int NW   = DW + FB + 1;
   localparam int LSTEP = POS_NODE1 - 1;
   localparam int MSTEP = POS_NODE2 - POS_NODE1;
   localparam int RSTEP = POS_TOP - POS_NODE2 - 1;

   logic [NW-1:0] num_sh;
   logic [NW-1:0] den_x;
   logic [NW-1:0] quo;
   logic [31:0]   f;
   logic [31:0]   v;

   assign num_sh = NW'({num, {FB{1'b0}}});
   assign den_x  = NW'(den);

   generate
      if (NW <= 32) begin : g_narrow
         assign quo = (den_x == '0) ? '0 : (num_sh / den_x);
      end else begin : g_wide
         logic [NW-1:0] q_w;
         assign q_w = (den_x == '0) ? '0 : (num_sh / den_x);
         assign quo = q_w;
      end
   endgenerate

   // quotient never exceeds ONE since num <= den
   assign f = 32'(quo[FB:0]);

   always_comb begin
      unique case (seg)
         SEG_LEFT: begin
            if (f < 32'(END_ZONE)) v = 32'd0;
            else v = 32'd1 + ((f - 32'(END_ZONE)) * 32'(LSTEP)) / 32'(SPAN);
         end
         SEG_RIGHT: begin
            if (f >= 32'(SPAN)) v = 32'(POS_TOP);
            else v = 32'(POS_NODE2) + (f * 32'(RSTEP)) / 32'(SPAN);
         end
         default: begin
            v = 32'(POS_NODE1) + (f * 32'(MSTEP)) / 32'(ONE);
         end
      endcase
   end

   assign pos = v[6:0];

endmodule

// File: rtl/slider_pos_top.sv
module slider_pos_top #(
   parameter int DW       = 12,
   parameter int FB       = 8,
   parameter int THRESH   = 40,
   parameter int END_ZONE = 77
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid_i,
   input  logic [DW-1:0] end_delta_i,
   input  logic [DW-1:0] node1_delta_i,
   input  logic [DW-1:0] node2_delta_i,
   output logic          out_valid_o,
   output logic          touch_o,
   output logic [6:0]    pos_o,
   output logic [7:0]    status_o
);
   import slider_pkg::*;

   initial begin
      if (DW < 2 || DW > 24) $fatal(1, "slider_pos_top: DW out of range");
      if (FB < 4 || FB > 12) $fatal(1, "slider_pos_top: FB out of range");
      if (END_ZONE < 1 || END_ZONE >= (1 << FB))
         $fatal(1, "slider_pos_top: END_ZONE out of range");
      if (THRESH < 0) $fatal(1, "slider_pos_top: THRESH negative");
   end

   logic          touch_c;
   seg_e          seg_c;
   logic [DW-1:0] num_c;
   logic [DW:0]   den_c;
   logic [6:0]    pos_c;

   slider_spread #(.DW(DW), .THRESH(THRESH)) u_spread (
      .ch_end (end_delta_i),
      .ch_n1  (node1_delta_i),
      .ch_n2  (node2_delta_i),
      .touch  (touch_c),
      .seg    (seg_c),
      .num    (num_c),
      .den    (den_c)
   );

   slider_interp #(.DW(DW), .FB(FB), .END_ZONE(END_ZONE)) u_interp (
      .seg (seg_c),
      .num (num_c),
      .den (den_c),
      .pos (pos_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid_o <= 1'b0;
         touch_o     <= 1'b0;
         pos_o       <= '0;
      end else begin
         out_valid_o <= in_valid_i;
         if (in_valid_i) begin
            touch_o <= touch_c;
            if (touch_c) pos_o <= pos_c;
         end
      end
   end

   assign status_o = {touch_o, pos_o};

endmodule

// File: rtl/slider_pos_chk.sv
module slider_pos_chk #(
   parameter int DW     = 12,
   parameter int THRESH = 40
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid_i,
   input logic [DW-1:0] end_delta_i,
   input logic [DW-1:0] node1_delta_i,
   input logic [DW-1:0] node2_delta_i,
   input logic          out_valid_o,
   input logic          touch_o,
   input logic [6:0]    pos_o,
   input logic [7:0]    status_o
);
   localparam logic [DW-1:0] THR_V = DW'(THRESH);

   logic [DW-1:0] d_en1, d_en2, d_n12;
   logic          any_far, all_eq, n1_only;

   assign d_en1 = (end_delta_i > node1_delta_i) ? end_delta_i - node1_delta_i
                                                : node1_delta_i - end_delta_i;
   assign d_en2 = (end_delta_i > node2_delta_i) ? end_delta_i - node2_delta_i
                                                : node2_delta_i - end_delta_i;
   assign d_n12 = (node1_delta_i > node2_delta_i) ? node1_delta_i - node2_delta_i
                                                  : node2_delta_i - node1_delta_i;
   assign any_far = (d_en1 > THR_V) || (d_en2 > THR_V) || (d_n12 > THR_V);
   assign all_eq  = (end_delta_i == node1_delta_i) && (node1_delta_i == node2_delta_i);
   assign n1_only = (end_delta_i == '0) && (node2_delta_i == '0) && (node1_delta_i > THR_V);

   p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid_i |=> out_valid_o);
   p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid_i |=> !out_valid_o);
   p_detect_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid_i |=> (touch_o == $past(any_far)));
   p_common_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && all_eq) |=> !touch_o);
   p_node1_anchor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && n1_only) |=> (pos_o == 7'd45));
   p_hold_untouched_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && !any_far) |=> $stable(pos_o));
   p_status_bit7_r8: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[7] == touch_o && status_o[6:0] == pos_o);
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid_i |=> ($stable(touch_o) && $stable(pos_o)));

endmodule

bind slider_pos_top slider_pos_chk #(.DW(DW), .THRESH(THRESH)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_valid_i    (in_valid_i),
   .end_delta_i   (end_delta_i),
   .node1_delta_i (node1_delta_i),
   .node2_delta_i (node2_delta_i),
   .out_valid_o   (out_valid_o),
   .touch_o       (touch_o),
   .pos_o         (pos_o),
   .status_o      (status_o)
);

// File: tb/tb_slider_pos_top.sv
`timescale 1ns/1ps
module tb_slider_pos_top;
   localparam int DW = 12;
   localparam int THRESH = 40;
   localparam int EZ = 77;
   localparam int ONE = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid_i = 1'b0;
   logic [DW-1:0] end_delta_i = '0;
   logic [DW-1:0] node1_delta_i = '0;
   logic [DW-1:0] node2_delta_i = '0;
   logic          out_valid_o;
   logic          touch_o;
   logic [6:0]    pos_o;
   logic [7:0]    status_o;

   int n_checks = 0;
   int n_fail   = 0;
   int model_pos = 0;
   bit finished = 0;

   typedef struct {
      bit    det;
      int    pos;
      string tag;
   } exp_t;
   exp_t sb[$];

   always #10 clk = ~clk;

   slider_pos_top #(.DW(DW), .THRESH(THRESH), .END_ZONE(EZ)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i),
      .end_delta_i(end_delta_i), .node1_delta_i(node1_delta_i),
      .node2_delta_i(node2_delta_i), .out_valid_o(out_valid_o),
      .touch_o(touch_o), .pos_o(pos_o), .status_o(status_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int pos_model(input int e, input int a, input int b);
      int f, nm, dn;
      if (e <= a && e <= b) begin       // R6 middle
         nm = b; dn = a + b;
         f = (dn == 0) ? 0 : (nm * ONE) / dn;
         return 45 + (f * 38) / ONE;    // R4
      end else if (a >= b) begin        // R6 left
         f = (a * ONE) / (e + a);
         if (f < EZ) return 0;          // R3
         return 1 + ((f - EZ) * 44) / (ONE - EZ);
      end else begin                    // R6 right
         f = (e * ONE) / (b + e);
         if (f >= ONE - EZ) return 127; // R5
         return 83 + (f * 43) / (ONE - EZ);
      end
   endfunction

   task automatic drive(input int e, input int a, input int b, input string tag);
      int mx, mn;
      exp_t x;
      mx = (e > a) ? e : a; mx = (b > mx) ? b : mx;
      mn = (e < a) ? e : a; mn = (b < mn) ? b : mn;
      x.det = ((mx - mn) > THRESH);     // R1
      if (x.det) model_pos = pos_model(e, a, b);
      x.pos = model_pos;                // R8 hold
      x.tag = tag;
      @(negedge clk);
      in_valid_i    = 1'b1;
      end_delta_i   = DW'(e);
      node1_delta_i = DW'(a);
      node2_delta_i = DW'(b);
      sb.push_back(x);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid_i = 1'b0;
      end
   endtask

   // monitor: scoreboard pop and compare
   always @(negedge clk) begin
      if (rst_n && out_valid_o) begin
         if (sb.size() == 0) begin
            check(1'b0, "R7 unexpected out_valid", 1, 0);
         end else begin
            exp_t x;
            x = sb.pop_front();
            check(touch_o == x.det, {x.tag, " touch"}, int'(touch_o), int'(x.det));
            check(int'(pos_o) == x.pos, {x.tag, " pos"}, int'(pos_o), x.pos);
            check(status_o == {x.det, 7'(x.pos)}, {x.tag, " R8 status"},
                  int'(status_o), int'({x.det, 7'(x.pos)}));
         end
      end
   end

   initial begin
      #(20 * 150000);
      if (!finished) begin
         check(1'b0, "watchdog", 0, 1);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid_o == 1'b0 && touch_o == 1'b0 && pos_o == 7'd0 && status_o == 8'd0,
            "R9 reset state", int'(status_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      drive(500, 500, 500, "R2 common mode");
      drive(4000, 4000, 4000, "R2 common mode high");
      drive(100, 130, 110, "R1 small spread");
      drive(100, 140, 100, "R1 spread at threshold");
      drive(100, 141, 100, "R1 spread above threshold");
      drive(0, 800, 0, "R4 node1 anchor");
      drive(0, 0, 800, "R4 node2 anchor");
      drive(300, 300, 300, "R8 hold after untouched");
      drive(800, 0, 0, "R3 left end stop");
      drive(800, 60, 0, "R3 left zone");
      drive(300, 300, 0, "R3 left track");
      drive(800, 0, 50, "R5 right end stop");
      drive(300, 0, 300, "R5 right track");
      drive(100, 50, 50, "R6 tie to left");
      drive(50, 50, 200, "R6 tie to middle");
      for (int k = 0; k <= 8; k++) begin
         drive(k * 100, 800 - k * 100, 0, "R3 left sweep");
         drive(0, 800 - k * 100, k * 100, "R4 middle sweep");
         drive(k * 100, 0, 800 - k * 100, "R5 right sweep");
      end
      drive(0, 0, 900, "R10 last touched");
      idle(1);
      @(negedge clk);
      check(out_valid_o == 1'b0, "R7 no pulse when idle", int'(out_valid_o), 0);
      end_delta_i = 12'd900; node1_delta_i = 12'd0; node2_delta_i = 12'd0;
      idle(3);
      check(touch_o == 1'b1 && pos_o == 7'd83, "R10 idle hold", int'(pos_o), 83);
      check(sb.size() == 0, "R7 all results seen", sb.size(), 0);
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule